// File: doc/BRIEF.md
# UART Automatic Hardware Handshake Controller

This block sits beside a UART receive FIFO and a UART transmitter and runs the RTS/CTS handshake with no software involvement. On the receive side it watches the FIFO fill count. It drives the active-low RTS line high (off) when the FIFO climbs to the trigger level one step above the programmed one. It drives RTS low again once the FIFO drains to the level one step below. The FIFO keeps accepting characters while RTS is off, so that logic is outside this block.

On the transmit side the active-low CTS line is synchronised through two flops. A stop request (CTS high) lets the character in flight finish, including its stop bit, and then withholds permission to start a new character. Permission returns once CTS goes low. A rising CTS edge can also raise a sticky interrupt flag. A read of the interrupt status clears that flag.

Top module: `uart_auto_flow`

## Requirements
- R1: After reset, rts_n is 0, tx_allow is 1 and cts_irq is 0.
- R2: With auto_rts_en=1, rts_n goes to 1 one cycle after rx_level reaches the off level. For trig_sel 00/01/10/11, the programmed levels are 8/16/24/28 and the off levels are 16/24/28/28.
- R3: With auto_rts_en=1 and rts_n=1, rts_n returns to 0 one cycle after rx_level falls to the on level. The on levels are 0/7/15/23 for trig_sel 00/01/10/11. Between the on level and the off level, rts_n holds its value.
- R4: With auto_rts_en=0, rts_n is 0 one cycle later, whatever rx_level is.
- R5: When auto_cts_en=1, cts_n has been 1 for three clock edges and tx_busy=1, tx_allow stays 1 until tx_stop_done pulses. It is 0 from the edge that samples that pulse.
- R6: When auto_cts_en=1 and the transmitter is idle (tx_busy=0), tx_allow is 0 on the third clock edge after cts_n becomes 1.
- R7: tx_allow is 1 again on the third clock edge after cts_n returns to 0.
- R8: With auto_cts_en=0, tx_allow stays 1 whatever cts_n does, and no interrupt is raised.
- R9: A 0-to-1 transition of synchronised cts_n sets cts_irq only when auto_cts_en=1 and both bits of cts_int_en are 1.
- R10: A status_rd pulse clears cts_irq at the next edge. A new CTS rising edge in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 6 | Receive FIFO fill count, 0 to 32 |
| trig_sel | input | 2 | Trigger level code: 00=8, 01=16, 10=24, 11=28 |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| auto_cts_en | input | 1 | Enables automatic CTS control |
| cts_int_en | input | 2 | Both bits must be set for the CTS interrupt |
| cts_n | input | 1 | Asynchronous CTS line, 1 = stop request |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_stop_done | input | 1 | One-cycle strobe when the stop bit has gone out |
| status_rd | input | 1 | Interrupt status read strobe |
| rts_n | output | 1 | RTS line, 0 = ready to receive |
| tx_allow | output | 1 | Transmitter may start a new character |
| cts_irq | output | 1 | Sticky CTS stop-request interrupt flag |

## Verification
The bench sweeps the fill count up and down across every trigger code, with random excursions inside the hysteresis band. A design with a single threshold, or with off-by-one levels, would toggle RTS in the wrong cycle. It raises CTS while a character is in flight and checks that permission is held until the stop strobe. A design that gates at once would cut a character short, and one that ignores the strobe would never stop. It also checks the interrupt against each enable combination and against a read in the same cycle as a new edge. A wrong gate or a wrong priority would lose or invent an interrupt.

// File: rtl/uart_auto_flow.sv
module uart_auto_flow #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [1:0]    trig_sel,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic [1:0]    cts_int_en,
  input  logic          cts_n,
  input  logic          tx_busy,
  input  logic          tx_stop_done,
  input  logic          status_rd,
  output logic          rts_n,
  output logic          tx_allow,
  output logic          cts_irq
);
  localparam int Q1 = DEPTH / 4;
  localparam int Q2 = DEPTH / 2;
  localparam int Q3 = 3 * DEPTH / 4;
  localparam int Q4 = DEPTH - 4;

  logic [LW-1:0] off_lvl, on_lvl;
  always_comb begin
    unique case (trig_sel)
      2'd0: begin off_lvl = LW'(Q2); on_lvl = '0;          end
      2'd1: begin off_lvl = LW'(Q3); on_lvl = LW'(Q1 - 1); end
      2'd2: begin off_lvl = LW'(Q4); on_lvl = LW'(Q2 - 1); end
      default: begin off_lvl = LW'(Q4); on_lvl = LW'(Q3 - 1); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  rts_n <= 1'b0;
    else if (!auto_rts_en)       rts_n <= 1'b0;
    else if (rx_level >= off_lvl) rts_n <= 1'b1;
    else if (rx_level <= on_lvl)  rts_n <= 1'b0;

  logic cts_m, cts_s, cts_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cts_m, cts_s, cts_d} <= 3'b000;
    else        {cts_m, cts_s, cts_d} <= {cts_n, cts_m, cts_s};

  wire stop_req = auto_cts_en & cts_s;
  wire cts_rise = auto_cts_en & cts_s & ~cts_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         tx_allow <= 1'b1;
    else if (!stop_req)                 tx_allow <= 1'b1;
    else if (!tx_busy || tx_stop_done)  tx_allow <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cts_irq <= 1'b0;
    else if (cts_rise && &cts_int_en)  cts_irq <= 1'b1;
    else if (status_rd)                cts_irq <= 1'b0;
endmodule

module uart_auto_flow_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] rx_level,
  input logic          auto_rts_en,
  input logic          auto_cts_en,
  input logic [1:0]    cts_int_en,
  input logic          tx_busy,
  input logic          tx_stop_done,
  input logic          status_rd,
  input logic          rts_n,
  input logic          tx_allow,
  input logic          cts_irq
);
  assert_rts_off_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(auto_rts_en) && ($past(rx_level) >= LW'(DEPTH / 2)));
  assert_rts_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> !rts_n);
  assert_stop_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_allow) |-> !$past(tx_busy) || $past(tx_stop_done));
  assert_cts_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_allow);
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_irq) |-> $past(auto_cts_en) && $past(&cts_int_en));
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cts_irq) |-> $past(status_rd));
endmodule

bind uart_auto_flow uart_auto_flow_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .auto_rts_en(auto_rts_en),
  .auto_cts_en(auto_cts_en), .cts_int_en(cts_int_en), .tx_busy(tx_busy),
  .tx_stop_done(tx_stop_done), .status_rd(status_rd), .rts_n(rts_n),
  .tx_allow(tx_allow), .cts_irq(cts_irq));

// File: tb/test_uart_auto_flow.sv
module test_uart_auto_flow;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] rx_level = '0;
  logic [1:0] trig_sel = '0, cts_int_en = '0;
  logic auto_rts_en = 1'b0, auto_cts_en = 1'b0, cts_n = 1'b0;
  logic tx_busy = 1'b0, tx_stop_done = 1'b0, status_rd = 1'b0;
  logic rts_n, tx_allow, cts_irq;
  int checks = 0, failures = 0;
  logic exp_rts = 1'b0;

  always #2 clk = ~clk;

  uart_auto_flow i_uart_auto_flow (.*);

  function automatic int off_of(input logic [1:0] t);
    case (t) 2'd0: return 16; 2'd1: return 24; default: return 28; endcase
  endfunction
  function automatic int on_of(input logic [1:0] t);
    case (t) 2'd0: return 0; 2'd1: return 7; 2'd2: return 15; default: return 23; endcase
  endfunction
  function automatic logic rts_next(input logic cur, input logic en,
                                    input int lvl, input logic [1:0] t);
    if (!en) return 1'b0;
    if (lvl >= off_of(t)) return 1'b1;
    if (lvl <= on_of(t)) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic rts_step(input int lvl, input string req);
    logic nx;
    rx_level = 6'(lvl);
    nx = rts_next(exp_rts, auto_rts_en, lvl, trig_sel);
    @(posedge clk); @(negedge clk);
    chk(req, rts_n, nx);
    exp_rts = nx;
  endtask

  task automatic wait3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int unused = $urandom(1234);
    repeat (3) @(negedge clk);
    chk("R1 rts_n", rts_n, 1'b0);
    chk("R1 tx_allow", tx_allow, 1'b1);
    chk("R1 cts_irq", cts_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    auto_rts_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      trig_sel = 2'(t);
      for (int l = 0; l <= 32; l++) rts_step(l, "R2 ramp up");
      for (int l = 32; l >= 0; l--) rts_step(l, "R3 ramp down");
    end
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 40 == 0) trig_sel = 2'($urandom);
      auto_rts_en = ($urandom % 16) != 0;
      rts_step(int'($urandom % 33), auto_rts_en ? "R3 random hysteresis" : "R4 random disabled");
    end
    auto_rts_en = 1'b1; trig_sel = 2'd1;
    rts_step(30, "R2 off at high fill");
    auto_rts_en = 1'b0;
    rts_step(30, "R4 disable forces on");

    auto_cts_en = 1'b1; cts_int_en = 2'b11; tx_busy = 1'b1; cts_n = 1'b1;
    wait3();
    chk("R5 held while busy", tx_allow, 1'b1);
    chk("R9 irq set", cts_irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R5 still held", tx_allow, 1'b1);
    tx_stop_done = 1'b1;
    @(negedge clk); tx_stop_done = 1'b0;
    chk("R5 stop after stop bit", tx_allow, 1'b0);
    tx_busy = 1'b0;
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    chk("R10 read clears", cts_irq, 1'b0);
    cts_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R7 not yet resumed", tx_allow, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7 resumed", tx_allow, 1'b1);

    cts_n = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R6 before latency", tx_allow, 1'b1);
    status_rd = 1'b1;
    @(posedge clk); @(negedge clk); status_rd = 1'b0;
    chk("R6 idle stop", tx_allow, 1'b0);
    chk("R10 set wins over read", cts_irq, 1'b1);
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    cts_n = 1'b0; wait3();

    cts_int_en = 2'b01; cts_n = 1'b1; wait3();
    chk("R9 partial enable no irq", cts_irq, 1'b0);
    chk("R6 stop regardless of irq", tx_allow, 1'b0);
    cts_n = 1'b0; wait3();

    auto_cts_en = 1'b0; cts_int_en = 2'b11; cts_n = 1'b1; wait3();
    repeat (3) @(negedge clk);
    chk("R8 allow kept", tx_allow, 1'b1);
    chk("R8 no irq", cts_irq, 1'b0);
    cts_n = 1'b0; wait3();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule